// File: doc/BRIEF.md
# Latency-Ordered Response Slot Buffer

This block holds the answers that a memory model owes to a group of cache ports and hands them back once their latency has run out. Each accepted request that needs an answer arrives with a response record (thread id, packet id, a two-bit error code and a number of data words) and a latency value. The buffer stores the record in a slot and counts that latency down by one per cycle. It keeps the occupied slots sorted by remaining delay, so the answers that will be ready soonest sit at the lowest positions.

The block has several response ports, and response port i always carries the slot at position i. Its valid output is raised once that slot's delay has reached zero. A slot leaves the buffer when its port is valid and the consumer acknowledges it in the same cycle. The positions above it then close the gap. Request acknowledges are handed out by position: port i is acknowledged only while more than i slots are free. All acknowledged pushes in one cycle therefore always fit. Pops and pushes of the same cycle both land at the next edge, with the pops taken first.

Top module: `resp_slot_buffer`

## Requirements
- R1: A synchronous active-high reset empties every slot. After reset every `rsp_val` bit is low and every `req_ack` bit is high.
- R2: `req_ack[i]` is high exactly when i is less than the number of free slots (DEPTH minus occupied slots). The count is taken before that cycle's pops.
- R3: A push happens at an edge where `req_val[i]` and `req_ack[i]` are both high. The stored record (tid, pid, err, data) comes back unchanged on a response port. Error code 2'b00 means no error and 2'b01 means bus error.
- R4: A record pushed at edge n with latency L has remaining delay L after that edge. Its delay drops by one at each later edge while above zero, and it can first be valid in the cycle after edge n+L. With L = 0 it can be valid in the cycle right after acceptance.
- R5: Response port i presents the slot at position i. `rsp_val[i]` is low when fewer than i+1 slots are occupied, and otherwise equals (remaining delay of slot i == 0).
- R6: Slots are kept in ascending order of remaining delay, and equal delays stay in arrival order. Pushes of the same cycle count as arriving in port order, lowest port first.
- R7: At an edge where `rsp_val[i]` and `rsp_ack[i]` are both high, slot i is removed. Several ports may pop in one cycle. The survivors keep their relative order and move down to fill the gaps.
- R8: `rsp_ack[i]` while `rsp_val[i]` is low removes nothing and changes no slot.
- R9: A cycle's pushes are applied after that cycle's pops. At full occupancy no push is accepted, even in a cycle with a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_val | input | NPORT | Request carries a record to store, per port |
| req_ack | output | NPORT | Slot available for this port's push |
| req_lat | input | NPORT x LAT_W | Latency of each pushed record |
| req_tid | input | NPORT x TID_W | Thread id of each pushed record |
| req_pid | input | NPORT x PID_W | Packet id of each pushed record |
| req_err | input | NPORT x 2 | Error code of each pushed record |
| req_data | input | NPORT x NWORD*WORD_W | Data words of each pushed record |
| rsp_val | output | NPORT | Slot i is present with zero remaining delay |
| rsp_ack | input | NPORT | Consumer takes the response on port i |
| rsp_tid | output | NPORT x TID_W | Thread id of slot i |
| rsp_pid | output | NPORT x PID_W | Packet id of slot i |
| rsp_err | output | NPORT x 2 | Error code of slot i |
| rsp_data | output | NPORT x NWORD*WORD_W | Data words of slot i |

## Verification
The bench pushes two records in one cycle whose latencies are in the reverse of port order. A design that sorted by arrival alone would then show the wrong thread id on port 0. It pops both ports in one cycle, which exposes a design that walks removals upward and so drops or duplicates a slot. It also pulses the response acknowledge while no slot is ready, where a careless pop would lose a pending answer. Finally it fills the buffer and pops at full occupancy in the same cycle as new requests. A design that took the free count after pops would accept a push it had not acknowledged, and a design that lost count would keep the acknowledges low or let one through too early.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int ERR_W = 2;
  typedef enum logic [ERR_W-1:0] {
    RSP_OK      = 2'b00,
    RSP_BUS_ERR = 2'b01
  } rsp_err_e;
endpackage

// File: rtl/rsb_compact.sv
// Removes popped positions, closes the gaps and counts every survivor down.
module rsb_compact #(
  parameter int DEPTH = 8,
  parameter int NPORT = 2,
  parameter int REC_W = 42,
  parameter int LAT_W = 4,
  parameter int CNT_W = 4
) (
  input  logic [DEPTH-1:0][REC_W-1:0] in_rec,
  input  logic [DEPTH-1:0][LAT_W-1:0] in_dly,
  input  logic [CNT_W-1:0]            in_cnt,
  input  logic [NPORT-1:0]            pop,
  output logic [DEPTH-1:0][REC_W-1:0] out_rec,
  output logic [DEPTH-1:0][LAT_W-1:0] out_dly,
  output logic [CNT_W-1:0]            out_cnt
);
  logic [DEPTH-1:0] pop_ext;
  assign pop_ext = DEPTH'(pop);

  always_comb begin
    int w;
    w = 0;
    out_rec = '0;
    out_dly = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (j < int'(in_cnt) && !pop_ext[j]) begin
        out_rec[w] = in_rec[j];
        out_dly[w] = (in_dly[j] == '0) ? '0 : in_dly[j] - LAT_W'(1);
        w++;
      end
    end
    out_cnt = CNT_W'(w);
  end
endmodule

// File: rtl/rsb_insert.sv
// One insertion stage: places a record behind every slot whose delay is not larger.
module rsb_insert #(
  parameter int DEPTH = 8,
  parameter int REC_W = 42,
  parameter int LAT_W = 4,
  parameter int CNT_W = 4
) (
  input  logic                        en,
  input  logic [LAT_W-1:0]            key,
  input  logic [REC_W-1:0]            rec,
  input  logic [DEPTH-1:0][REC_W-1:0] in_rec,
  input  logic [DEPTH-1:0][LAT_W-1:0] in_dly,
  input  logic [CNT_W-1:0]            in_cnt,
  output logic [DEPTH-1:0][REC_W-1:0] out_rec,
  output logic [DEPTH-1:0][LAT_W-1:0] out_dly,
  output logic [CNT_W-1:0]            out_cnt
);
  always_comb begin
    int pos;
    pos = 0;
    for (int j = 0; j < DEPTH; j++)
      if (j < int'(in_cnt) && in_dly[j] <= key) pos++;
    for (int j = 0; j < DEPTH; j++) begin
      if (!en || j < pos) begin
        out_rec[j] = in_rec[j];
        out_dly[j] = in_dly[j];
      end else if (j == pos) begin
        out_rec[j] = rec;
        out_dly[j] = key;
      end else begin
        out_rec[j] = in_rec[(j > 0) ? j - 1 : 0];
        out_dly[j] = in_dly[(j > 0) ? j - 1 : 0];
      end
    end
    out_cnt = en ? in_cnt + CNT_W'(1) : in_cnt;
  end
endmodule

// File: rtl/resp_slot_buffer.sv
module resp_slot_buffer
  import rsb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NPORT  = 2,
  parameter int TID_W  = 4,
  parameter int PID_W  = 4,
  parameter int NWORD  = 2,
  parameter int WORD_W = 16,
  parameter int LAT_W  = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NPORT-1:0]                    req_val,
  output logic [NPORT-1:0]                    req_ack,
  input  logic [NPORT-1:0][LAT_W-1:0]         req_lat,
  input  logic [NPORT-1:0][TID_W-1:0]         req_tid,
  input  logic [NPORT-1:0][PID_W-1:0]         req_pid,
  input  logic [NPORT-1:0][ERR_W-1:0]         req_err,
  input  logic [NPORT-1:0][NWORD*WORD_W-1:0]  req_data,
  output logic [NPORT-1:0]                    rsp_val,
  input  logic [NPORT-1:0]                    rsp_ack,
  output logic [NPORT-1:0][TID_W-1:0]         rsp_tid,
  output logic [NPORT-1:0][PID_W-1:0]         rsp_pid,
  output logic [NPORT-1:0][ERR_W-1:0]         rsp_err,
  output logic [NPORT-1:0][NWORD*WORD_W-1:0]  rsp_data
);
  localparam int DATA_W = NWORD * WORD_W;
  localparam int REC_W  = TID_W + PID_W + ERR_W + DATA_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  // slot registers, position 0 = smallest remaining delay
  logic [DEPTH-1:0][REC_W-1:0] rec_q;
  logic [DEPTH-1:0][LAT_W-1:0] dly_q;
  logic [CNT_W-1:0]            cnt_q;

  logic [NPORT-1:0] pop, push;

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      req_ack[i] = (i < (DEPTH - int'(cnt_q)));
      rsp_val[i] = (i < int'(cnt_q)) && (dly_q[i] == '0);
    end
  end

  assign pop  = rsp_val & rsp_ack;
  assign push = req_val & req_ack;

  genvar g;
  generate
    for (g = 0; g < NPORT; g++) begin : g_out
      assign rsp_tid[g]  = rec_q[g][REC_W-1 -: TID_W];
      assign rsp_pid[g]  = rec_q[g][DATA_W+ERR_W +: PID_W];
      assign rsp_err[g]  = rec_q[g][DATA_W +: ERR_W];
      assign rsp_data[g] = rec_q[g][DATA_W-1:0];
    end
  endgenerate

  // pops first, then the countdown
  logic [DEPTH-1:0][REC_W-1:0] s_rec [NPORT+1];
  logic [DEPTH-1:0][LAT_W-1:0] s_dly [NPORT+1];
  logic [CNT_W-1:0]            s_cnt [NPORT+1];

  rsb_compact #(
    .DEPTH(DEPTH), .NPORT(NPORT), .REC_W(REC_W), .LAT_W(LAT_W), .CNT_W(CNT_W)
  ) u_compact (
    .in_rec (rec_q),
    .in_dly (dly_q),
    .in_cnt (cnt_q),
    .pop    (pop),
    .out_rec(s_rec[0]),
    .out_dly(s_dly[0]),
    .out_cnt(s_cnt[0])
  );

  // pushes after the pops, lowest port first
  generate
    for (g = 0; g < NPORT; g++) begin : g_ins
      rsb_insert #(
        .DEPTH(DEPTH), .REC_W(REC_W), .LAT_W(LAT_W), .CNT_W(CNT_W)
      ) u_ins (
        .en     (push[g]),
        .key    (req_lat[g]),
        .rec    ({req_tid[g], req_pid[g], req_err[g], req_data[g]}),
        .in_rec (s_rec[g]),
        .in_dly (s_dly[g]),
        .in_cnt (s_cnt[g]),
        .out_rec(s_rec[g+1]),
        .out_dly(s_dly[g+1]),
        .out_cnt(s_cnt[g+1])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dly_q <= '0;
      rec_q <= '0;
    end else begin
      cnt_q <= s_cnt[NPORT];
      dly_q <= s_dly[NPORT];
      rec_q <= s_rec[NPORT];
    end
  end
endmodule

// File: rtl/resp_slot_buffer_chk.sv
module resp_slot_buffer_chk #(
  parameter int NPORT = 2,
  parameter int TID_W = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NPORT-1:0]             req_ack,
  input logic [NPORT-1:0]             rsp_val,
  input logic [NPORT-1:0]             rsp_ack,
  input logic [NPORT-1:0][TID_W-1:0]  rsp_tid
);
  // R1: right after reset the buffer is empty
  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rsp_val == '0 && req_ack == '1));

  // R2: a full buffer stays full while nothing is popped
  assert_full_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (req_ack == '0 && (rsp_val & rsp_ack) == '0) |=> req_ack == '0);

  // R7: an unaccepted ready head stays in place and keeps its record
  assert_head_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_val[0] && !rsp_ack[0]) |=> (rsp_val[0] && rsp_tid[0] == $past(rsp_tid[0])));

  // R6: ordering by delay makes ready ports a prefix
  genvar i;
  generate
    for (i = 1; i < NPORT; i++) begin : g_pref
      assert_val_prefix_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_val[i] |-> rsp_val[i-1]);
    end
  endgenerate
endmodule

bind resp_slot_buffer resp_slot_buffer_chk #(.NPORT(NPORT), .TID_W(TID_W)) u_chk (
  .clk(clk), .rst(rst), .req_ack(req_ack), .rsp_val(rsp_val),
  .rsp_ack(rsp_ack), .rsp_tid(rsp_tid)
);

// File: tb/sim_resp_slot_buffer.sv
module sim_resp_slot_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8, NPORT = 2, TID_W = 4, PID_W = 4;
  localparam int NWORD = 2, WORD_W = 16, LAT_W = 4;

  logic clk = 0, rst = 1;
  logic [1:0] req_val = 0, req_ack, rsp_val, rsp_ack = 0;
  logic [1:0][3:0]  req_lat = 0, req_tid = 0, req_pid = 0, rsp_tid, rsp_pid;
  logic [1:0][1:0]  req_err = 0, rsp_err;
  logic [1:0][31:0] req_data = 0, rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  resp_slot_buffer #(.DEPTH(DEPTH), .NPORT(NPORT), .TID_W(TID_W), .PID_W(PID_W),
    .NWORD(NWORD), .WORD_W(WORD_W), .LAT_W(LAT_W)) u0 (.*);

  typedef struct {
    logic [3:0] tid; logic [3:0] pid; logic [1:0] err; logic [31:0] data; int dly;
  } ent_t;
  ent_t mq[$];

  int total = 0, bad = 0, cyc = 0, tid_ctr = 0;
  bit done = 0;
  string phase = "init";

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s [%s]: got %0h expected %0h", tag, phase, got, exp);
    end
  endtask

  function automatic logic [1:0] exp_ack();
    for (int i = 0; i < NPORT; i++) exp_ack[i] = (i < DEPTH - mq.size());
  endfunction

  function automatic logic [1:0] exp_val();
    for (int i = 0; i < NPORT; i++) exp_val[i] = (i < mq.size()) && (mq[i].dly == 0);
  endfunction

  task automatic compare();
    logic [1:0] ev;
    ev = exp_val();
    chk("R2 req_ack", 64'(req_ack), 64'(exp_ack()));
    chk("R5 R4 rsp_val", 64'(rsp_val), 64'(ev));
    for (int i = 0; i < NPORT; i++)
      if (ev[i])
        chk("R3 R6 record", 64'({rsp_tid[i], rsp_pid[i], rsp_err[i], rsp_data[i]}),
            64'({mq[i].tid, mq[i].pid, mq[i].err, mq[i].data}));
  endtask

  // one cycle: check outputs, drive inputs, advance the bench model
  task automatic step(input logic [1:0] rv, input int l0, input int l1, input logic [1:0] ra);
    logic [1:0] ev, ea;
    @(negedge clk);
    compare();
    ev = exp_val();
    ea = exp_ack();
    req_val = rv; rsp_ack = ra;
    req_lat[0] = 4'(l0); req_lat[1] = 4'(l1);
    for (int p = 0; p < NPORT; p++) begin
      req_tid[p] = 4'(tid_ctr); tid_ctr++;
      req_pid[p] = 4'($urandom);
      req_err[p] = ($urandom % 2 == 0) ? 2'b00 : 2'b01;
      req_data[p] = $urandom;
    end
    for (int i = NPORT - 1; i >= 0; i--)
      if (ev[i] && ra[i]) mq.delete(i);
    foreach (mq[k]) if (mq[k].dly > 0) mq[k].dly--;
    for (int p = 0; p < NPORT; p++)
      if (rv[p] && ea[p]) begin
        ent_t e;
        int pos;
        e.tid = req_tid[p]; e.pid = req_pid[p]; e.err = req_err[p];
        e.data = req_data[p]; e.dly = int'(req_lat[p]);
        pos = 0;
        foreach (mq[k]) if (mq[k].dly <= e.dly) pos++;
        mq.insert(pos, e);
      end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; req_val = 0; rsp_ack = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    mq.delete();
    phase = "R1 reset";
    chk("R1 req_ack after reset", 64'(req_ack), 64'(2'b11));
    chk("R1 rsp_val after reset", 64'(rsp_val), 64'(0));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog: got %0d cycles expected at most 100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();

    phase = "R4 zero latency";
    step(2'b01, 0, 0, 2'b00);
    step(2'b00, 0, 0, 2'b00);
    step(2'b00, 0, 0, 2'b01);
    step(2'b00, 0, 0, 2'b00);

    phase = "R6 reverse latencies";
    step(2'b11, 3, 1, 2'b00);
    repeat (4) step(2'b00, 0, 0, 2'b00);
    phase = "R7 dual pop";
    step(2'b00, 0, 0, 2'b11);
    step(2'b00, 0, 0, 2'b00);

    phase = "R8 ack without valid";
    step(2'b01, 5, 0, 2'b00);
    step(2'b00, 0, 0, 2'b11);
    repeat (6) step(2'b00, 0, 0, 2'b00);
    step(2'b00, 0, 0, 2'b01);

    phase = "R9 pop at full";
    repeat (4) step(2'b11, 9, 9, 2'b00);
    repeat (10) step(2'b00, 0, 0, 2'b00);
    step(2'b11, 2, 2, 2'b01);
    step(2'b11, 2, 2, 2'b00);
    repeat (12) step(2'b00, 0, 0, 2'b11);

    phase = "random";
    for (int n = 0; n < 3000; n++)
      step(2'($urandom), $urandom % 8, $urandom % 8, 2'($urandom));

    do_reset();
    phase = "R2 after reset";
    step(2'b11, 1, 0, 2'b00);
    step(2'b00, 0, 0, 2'b00);
    @(negedge clk);
    compare();

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule